// File: doc/BRIEF.md
# Day and Seconds Real-Time Counter with Alarm

This block keeps wall-clock time as two binary counts: a 17-bit seconds-of-day value and a 15-bit day number. A 1 Hz enable pulse, already synchronous to the block clock, advances the count. The seconds count wraps at the end of each day and carries into the day number. The whole count rolls over to zero after the last second of the last representable day.

Software reaches the time, an alarm time, two interrupt enables and two sticky status flags through a single-cycle register port. Register reads are combinational from the address. Writes take effect at the clock edge that samples them. Seconds-of-day is visible through two narrow windows, an 8-bit low byte and a 9-bit high part, with the day number in a third register. The seconds field is made of these two parts.

A time update is staged. Writes to the high part and to the day go into holding registers. The write of the low byte then loads all three into the running count at once, so a multi-register update cannot tear against a tick. Reads always return the running count. A reader can therefore see the high part move between two reads and must retry the day read when that happens.

Two level interrupts leave the block. One fires once per second. The other fires when the running time equals the alarm time.

Top module: `sec_day_rtc`

## Requirements
- R1: After reset, every readable register reads zero and both interrupt outputs are low.
- R2: A write to address 1 (high seconds, 9 bits) or address 2 (day, 15 bits) does not change what those addresses read. A later write to address 0 (low seconds byte) loads the running count as follows:
  - The written byte becomes the low byte.
  - Each field staged since the previous address-0 write is loaded from its holding register.
  - Each field not staged keeps its running value.
- R3: Each tick pulse adds one to seconds-of-day, visible on reads one clock edge later. A tick in the same cycle as an address-0 write is discarded: the count equals exactly the value written.
- R4: Seconds-of-day reads live. Address 0 returns bits 7:0 and address 1 returns bits 16:8, so a carry out of the low byte shows in the high part right after the tick.
- R5: A tick at seconds-of-day 86399 (or above) sets seconds to 0 and adds one to the day.
- R6: A tick at seconds-of-day 86399 with day 0x7FFF sets both seconds and day to 0.
- R7: Every tick sets the update flag, bit 0 of address 7. Writing a 1 to that bit clears it.
- R8: The alarm compare runs in the cycle after a tick or an address-0 write. It compares the running day and seconds with the alarm registers:
  - address 3 holds alarm bits 7:0;
  - address 4 holds alarm bits 16:8;
  - address 5 holds the alarm day.

  On a full match, the alarm flag (bit 1 of address 7) is set one edge after the count change and stays set until software writes a 1 to it.
- R9: Address 6 bit 0 enables the update interrupt and bit 1 enables the alarm interrupt. Each interrupt output equals its status flag ANDed with its enable.
- R10: The alarm and enable registers read back the written value, masked to their field widths.
- R11: A status write with a 0 in a flag position leaves that flag unchanged. A flag set and cleared in the same cycle ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle 1 Hz advance pulse, synchronous to clk_i |
| reg_sel_i | input | 1 | Register access valid |
| reg_wr_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | DATA_W (16) | Write data |
| reg_rdata_o | output | DATA_W (16) | Read data, combinational from reg_addr_i |
| irq_update_o | output | 1 | Once-per-second interrupt level |
| irq_alarm_o | output | 1 | Alarm-match interrupt level |

## Verification
The results appear at different clock edges after the stimulus:
- **Count and update flag:** a tick or a committing write updates both at the clock edge that samples it. The bench drives on the falling edge and reads at the next falling edge.
- **Alarm flag:** it needs one edge more, because the compare is registered behind the count. The bench reads status once at the first falling edge, where bit 1 must still be clear, and again one cycle later, where it must be set.
- **Interrupt outputs:** these are combinational from the flags and enables, so the bench checks them in the same cycle as the status read.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

    localparam int REG_ADDR_W = 3;

    typedef enum logic [REG_ADDR_W-1:0] {
        RA_TIME_LO  = 3'd0,
        RA_TIME_HI  = 3'd1,
        RA_TIME_DAY = 3'd2,
        RA_ALM_LO   = 3'd3,
        RA_ALM_HI   = 3'd4,
        RA_ALM_DAY  = 3'd5,
        RA_IRQ_EN   = 3'd6,
        RA_IRQ_STAT = 3'd7
    } sdr_addr_e;

    localparam int STAT_UPD_BIT = 0;
    localparam int STAT_ALM_BIT = 1;

endpackage

// File: rtl/sdr_regbank.sv
module sdr_regbank
    import sdr_pkg::*;
#(
    parameter int LO_W   = 8,
    parameter int HI_W   = 9,
    parameter int DAY_W  = 15,
    parameter int DATA_W = 16
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    sel_i,
    input  logic                    wr_i,
    input  logic [REG_ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]       wdata_i,
    input  logic [LO_W+HI_W-1:0]    live_sec_i,
    input  logic [DAY_W-1:0]        live_day_i,
    input  logic                    upd_flag_i,
    input  logic                    alm_flag_i,
    output logic [DATA_W-1:0]       rdata_o,
    output logic                    commit_o,
    output logic [LO_W+HI_W-1:0]    commit_sec_o,
    output logic [DAY_W-1:0]        commit_day_o,
    output logic [LO_W+HI_W-1:0]    alm_sec_o,
    output logic [DAY_W-1:0]        alm_day_o,
    output logic                    en_upd_o,
    output logic                    en_alm_o,
    output logic                    clr_upd_o,
    output logic                    clr_alm_o
);

    localparam int SEC_W = LO_W + HI_W;

    typedef struct packed {
        logic [HI_W-1:0]  hi_hold;
        logic [DAY_W-1:0] day_hold;
        logic             hi_staged;
        logic             day_staged;
        logic [SEC_W-1:0] alm_sec;
        logic [DAY_W-1:0] alm_day;
        logic             en_upd;
        logic             en_alm;
    } bank_t;

    bank_t     bank_d, bank_q;
    logic      wr_en;
    sdr_addr_e addr;
    logic      unused_wdata;

    assign wr_en        = sel_i && wr_i;
    assign addr         = sdr_addr_e'(addr_i);
    assign unused_wdata = ^wdata_i;

    // Next-state of the holding, alarm and enable registers
    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            case (addr)
                RA_TIME_LO: begin
                    bank_d.hi_staged  = 1'b0;
                    bank_d.day_staged = 1'b0;
                end
                RA_TIME_HI: begin
                    bank_d.hi_hold   = wdata_i[HI_W-1:0];
                    bank_d.hi_staged = 1'b1;
                end
                RA_TIME_DAY: begin
                    bank_d.day_hold   = wdata_i[DAY_W-1:0];
                    bank_d.day_staged = 1'b1;
                end
                RA_ALM_LO:  bank_d.alm_sec[LO_W-1:0]     = wdata_i[LO_W-1:0];
                RA_ALM_HI:  bank_d.alm_sec[SEC_W-1:LO_W] = wdata_i[HI_W-1:0];
                RA_ALM_DAY: bank_d.alm_day               = wdata_i[DAY_W-1:0];
                RA_IRQ_EN: begin
                    bank_d.en_upd = wdata_i[STAT_UPD_BIT];
                    bank_d.en_alm = wdata_i[STAT_ALM_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bank_q <= '0;
        else         bank_q <= bank_d;
    end

    // Commit of a staged time update on the low-byte write
    always_comb begin
        commit_o     = wr_en && (addr == RA_TIME_LO);
        commit_sec_o = {bank_q.hi_staged ? bank_q.hi_hold : live_sec_i[SEC_W-1:LO_W],
                        wdata_i[LO_W-1:0]};
        commit_day_o = bank_q.day_staged ? bank_q.day_hold : live_day_i;
        clr_upd_o    = wr_en && (addr == RA_IRQ_STAT) && wdata_i[STAT_UPD_BIT];
        clr_alm_o    = wr_en && (addr == RA_IRQ_STAT) && wdata_i[STAT_ALM_BIT];
    end

    // Read mux: time fields always come from the running count
    always_comb begin
        rdata_o = '0;
        case (addr)
            RA_TIME_LO:  rdata_o = DATA_W'(live_sec_i[LO_W-1:0]);
            RA_TIME_HI:  rdata_o = DATA_W'(live_sec_i[SEC_W-1:LO_W]);
            RA_TIME_DAY: rdata_o = DATA_W'(live_day_i);
            RA_ALM_LO:   rdata_o = DATA_W'(bank_q.alm_sec[LO_W-1:0]);
            RA_ALM_HI:   rdata_o = DATA_W'(bank_q.alm_sec[SEC_W-1:LO_W]);
            RA_ALM_DAY:  rdata_o = DATA_W'(bank_q.alm_day);
            RA_IRQ_EN: begin
                rdata_o[STAT_UPD_BIT] = bank_q.en_upd;
                rdata_o[STAT_ALM_BIT] = bank_q.en_alm;
            end
            RA_IRQ_STAT: begin
                rdata_o[STAT_UPD_BIT] = upd_flag_i;
                rdata_o[STAT_ALM_BIT] = alm_flag_i;
            end
            default: ;
        endcase
    end

    assign alm_sec_o = bank_q.alm_sec;
    assign alm_day_o = bank_q.alm_day;
    assign en_upd_o  = bank_q.en_upd;
    assign en_alm_o  = bank_q.en_alm;

endmodule

// File: rtl/sdr_counter.sv
module sdr_counter #(
    parameter int SEC_W       = 17,
    parameter int DAY_W       = 15,
    parameter int SEC_PER_DAY = 86400
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [SEC_W-1:0] load_sec_i,
    input  logic [DAY_W-1:0] load_day_i,
    output logic [SEC_W-1:0] sec_o,
    output logic [DAY_W-1:0] day_o
);

    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_DAY - 1);

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [DAY_W-1:0] day;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    // A load takes priority; a tick in the load cycle is dropped
    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d.sec = load_sec_i;
            cnt_d.day = load_day_i;
        end else if (tick_i) begin
            if (cnt_q.sec >= SEC_LAST) begin
                cnt_d.sec = '0;
                cnt_d.day = cnt_q.day + DAY_W'(1);
            end else begin
                cnt_d.sec = cnt_q.sec + SEC_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign sec_o = cnt_q.sec;
    assign day_o = cnt_q.day;

endmodule

// File: rtl/sdr_irq_flags.sv
module sdr_irq_flags #(
    parameter int SEC_W = 17,
    parameter int DAY_W = 15
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             commit_i,
    input  logic [SEC_W-1:0] sec_i,
    input  logic [DAY_W-1:0] day_i,
    input  logic [SEC_W-1:0] alm_sec_i,
    input  logic [DAY_W-1:0] alm_day_i,
    input  logic             clr_upd_i,
    input  logic             clr_alm_i,
    input  logic             en_upd_i,
    input  logic             en_alm_i,
    output logic             upd_flag_o,
    output logic             alm_flag_o,
    output logic             irq_upd_o,
    output logic             irq_alm_o
);

    typedef struct packed {
        logic eval;
        logic upd;
        logic alm;
    } flg_t;

    flg_t flg_d, flg_q;
    logic hit;

    assign hit = (sec_i == alm_sec_i) && (day_i == alm_day_i);

    // Set beats clear in the same cycle
    always_comb begin
        flg_d      = flg_q;
        flg_d.eval = tick_i || commit_i;
        flg_d.upd  = (flg_q.upd && !clr_upd_i) || tick_i;
        flg_d.alm  = (flg_q.alm && !clr_alm_i) || (flg_q.eval && hit);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flg_q <= '0;
        else         flg_q <= flg_d;
    end

    assign upd_flag_o = flg_q.upd;
    assign alm_flag_o = flg_q.alm;
    assign irq_upd_o  = flg_q.upd && en_upd_i;
    assign irq_alm_o  = flg_q.alm && en_alm_i;

endmodule

// File: rtl/sec_day_rtc.sv
module sec_day_rtc
    import sdr_pkg::*;
#(
    parameter int LO_W        = 8,
    parameter int HI_W        = 9,
    parameter int DAY_W       = 15,
    parameter int DATA_W      = 16,
    parameter int SEC_PER_DAY = 86400
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  tick_i,
    input  logic                  reg_sel_i,
    input  logic                  reg_wr_i,
    input  logic [REG_ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0]     reg_wdata_i,
    output logic [DATA_W-1:0]     reg_rdata_o,
    output logic                  irq_update_o,
    output logic                  irq_alarm_o
);

    localparam int SEC_W = LO_W + HI_W;

    logic [SEC_W-1:0] live_sec, commit_sec, alm_sec;
    logic [DAY_W-1:0] live_day, commit_day, alm_day;
    logic             commit, upd_flag, alm_flag;
    logic             en_upd, en_alm, clr_upd, clr_alm;

    sdr_regbank #(
        .LO_W(LO_W), .HI_W(HI_W), .DAY_W(DAY_W), .DATA_W(DATA_W)
    ) u_bank (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sel_i       (reg_sel_i),
        .wr_i        (reg_wr_i),
        .addr_i      (reg_addr_i),
        .wdata_i     (reg_wdata_i),
        .live_sec_i  (live_sec),
        .live_day_i  (live_day),
        .upd_flag_i  (upd_flag),
        .alm_flag_i  (alm_flag),
        .rdata_o     (reg_rdata_o),
        .commit_o    (commit),
        .commit_sec_o(commit_sec),
        .commit_day_o(commit_day),
        .alm_sec_o   (alm_sec),
        .alm_day_o   (alm_day),
        .en_upd_o    (en_upd),
        .en_alm_o    (en_alm),
        .clr_upd_o   (clr_upd),
        .clr_alm_o   (clr_alm)
    );

    sdr_counter #(
        .SEC_W(SEC_W), .DAY_W(DAY_W), .SEC_PER_DAY(SEC_PER_DAY)
    ) u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_i),
        .load_i    (commit),
        .load_sec_i(commit_sec),
        .load_day_i(commit_day),
        .sec_o     (live_sec),
        .day_o     (live_day)
    );

    sdr_irq_flags #(
        .SEC_W(SEC_W), .DAY_W(DAY_W)
    ) u_flags (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_i),
        .commit_i  (commit),
        .sec_i     (live_sec),
        .day_i     (live_day),
        .alm_sec_i (alm_sec),
        .alm_day_i (alm_day),
        .clr_upd_i (clr_upd),
        .clr_alm_i (clr_alm),
        .en_upd_i  (en_upd),
        .en_alm_i  (en_alm),
        .upd_flag_o(upd_flag),
        .alm_flag_o(alm_flag),
        .irq_upd_o (irq_update_o),
        .irq_alm_o (irq_alarm_o)
    );

endmodule

// File: rtl/sdr_rtc_chk.sv
module sdr_rtc_chk #(
    parameter int SEC_W       = 17,
    parameter int DAY_W       = 15,
    parameter int SEC_PER_DAY = 86400
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tick_i,
    input logic             commit,
    input logic [SEC_W-1:0] commit_sec,
    input logic [DAY_W-1:0] commit_day,
    input logic [SEC_W-1:0] live_sec,
    input logic [DAY_W-1:0] live_day,
    input logic [SEC_W-1:0] alm_sec,
    input logic [DAY_W-1:0] alm_day,
    input logic             upd_flag,
    input logic             alm_flag
);

    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_DAY - 1);
    localparam logic [DAY_W-1:0] DAY_MAX  = '1;

    // R2
    commit_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        commit |=> (live_sec == $past(commit_sec)) && (live_day == $past(commit_day)));

    // R3
    tick_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !commit && live_sec < SEC_LAST) |=>
            (live_sec == $past(live_sec) + SEC_W'(1)) && (live_day == $past(live_day)));

    // R5
    day_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !commit && live_sec == SEC_LAST && live_day != DAY_MAX) |=>
            (live_sec == '0) && (live_day == $past(live_day) + DAY_W'(1)));

    // R6
    full_rollover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !commit && live_sec == SEC_LAST && live_day == DAY_MAX) |=>
            (live_sec == '0) && (live_day == '0));

    // R7
    upd_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |=> upd_flag);

    // R8
    alm_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(alm_flag) |-> $past((live_sec == alm_sec) && (live_day == alm_day)));

endmodule

bind sec_day_rtc sdr_rtc_chk #(
    .SEC_W(SEC_W), .DAY_W(DAY_W), .SEC_PER_DAY(SEC_PER_DAY)
) u_rtc_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .commit    (commit),
    .commit_sec(commit_sec),
    .commit_day(commit_day),
    .live_sec  (live_sec),
    .live_day  (live_day),
    .alm_sec   (alm_sec),
    .alm_day   (alm_day),
    .upd_flag  (upd_flag),
    .alm_flag  (alm_flag)
);

// File: tb/test_sec_day_rtc.sv
module test_sec_day_rtc;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              sel = 1'b0;
    logic              wr = 1'b0;
    logic [2:0]        addr = 3'd0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              irq_upd, irq_alm;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_day_rtc i_sec_day_rtc (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tick_i      (tick),
        .reg_sel_i   (sel),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_update_o(irq_upd),
        .irq_alarm_o (irq_alm)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a,
                          input logic [DATA_W-1:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic tick_with_write(input logic [2:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        tick = 1'b1; sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        tick = 1'b0; sel = 1'b0; wr = 1'b0;
    endtask

    task automatic set_time(input logic [15:0] day, input logic [15:0] hi,
                            input logic [15:0] lo);
        wr_reg(3'd2, day);
        wr_reg(3'd1, hi);
        wr_reg(3'd0, lo);
    endtask

    task automatic t_reset();
        for (int a = 0; a < 8; a++) rd_chk("R1 reset read", 3'(a), '0);
        check("R1 irq_update at reset", DATA_W'(irq_upd), '0);
        check("R1 irq_alarm at reset", DATA_W'(irq_alm), '0);
    endtask

    task automatic t_staged_commit();
        wr_reg(3'd1, 16'h010);
        wr_reg(3'd2, 16'd5);
        rd_chk("R2 high staged, not visible", 3'd1, 16'h0);
        rd_chk("R2 day staged, not visible", 3'd2, 16'h0);
        wr_reg(3'd0, 16'h20);
        rd_chk("R2 low after commit", 3'd0, 16'h20);
        rd_chk("R2 high after commit", 3'd1, 16'h010);
        rd_chk("R2 day after commit", 3'd2, 16'd5);
    endtask

    task automatic t_tick_and_carry();
        pulse_tick();
        rd_chk("R3 tick increments low", 3'd0, 16'h21);
        wr_reg(3'd0, 16'hFF);
        rd_chk("R2 low-only write keeps high", 3'd1, 16'h010);
        rd_chk("R2 low-only write keeps day", 3'd2, 16'd5);
        pulse_tick();
        rd_chk("R4 low wraps on carry", 3'd0, 16'h00);
        rd_chk("R4 high advances on carry", 3'd1, 16'h011);
    endtask

    task automatic t_day_wrap();
        set_time(16'd3, 16'h151, 16'h7F);
        pulse_tick();
        rd_chk("R5 seconds wrap low", 3'd0, 16'h0);
        rd_chk("R5 seconds wrap high", 3'd1, 16'h0);
        rd_chk("R5 day increments", 3'd2, 16'd4);
        set_time(16'h7FFF, 16'h151, 16'h7F);
        pulse_tick();
        rd_chk("R6 rollover low", 3'd0, 16'h0);
        rd_chk("R6 rollover high", 3'd1, 16'h0);
        rd_chk("R6 rollover day", 3'd2, 16'h0);
    endtask

    task automatic t_commit_tick();
        set_time(16'd1, 16'h002, 16'h10);
        tick_with_write(3'd0, 16'h40);
        rd_chk("R3 tick dropped on commit, low", 3'd0, 16'h40);
        rd_chk("R3 tick dropped on commit, high", 3'd1, 16'h002);
    endtask

    task automatic t_update_irq();
        wr_reg(3'd7, 16'h3);
        rd_chk("R7 status cleared", 3'd7, 16'h0);
        pulse_tick();
        rd_chk("R7 update flag set by tick", 3'd7, 16'h1);
        check("R9 update irq masked", DATA_W'(irq_upd), '0);
        wr_reg(3'd6, 16'h1);
        rd_chk("R10 enable readback", 3'd6, 16'h1);
        check("R9 update irq enabled", DATA_W'(irq_upd), 16'h1);
        wr_reg(3'd7, 16'h0);
        rd_chk("R11 zero write keeps flag", 3'd7, 16'h1);
        wr_reg(3'd7, 16'h1);
        rd_chk("R7 W1C clears update flag", 3'd7, 16'h0);
        check("R9 update irq low after clear", DATA_W'(irq_upd), '0);
        tick_with_write(3'd7, 16'h1);
        rd_chk("R11 set wins over clear", 3'd7, 16'h1);
        wr_reg(3'd6, 16'h0);
    endtask

    task automatic t_alarm_tick();
        set_time(16'd2, 16'h0, 16'h10);
        wr_reg(3'd3, 16'hFF11);
        wr_reg(3'd4, 16'hFE00);
        wr_reg(3'd5, 16'h8002);
        rd_chk("R10 alarm low readback masked", 3'd3, 16'h11);
        rd_chk("R10 alarm high readback masked", 3'd4, 16'h000);
        rd_chk("R10 alarm day readback masked", 3'd5, 16'h2);
        wr_reg(3'd6, 16'h2);
        wr_reg(3'd7, 16'h3);
        pulse_tick();
        rd_chk("R8 alarm not yet set one edge after tick", 3'd7, 16'h1);
        @(negedge clk);
        rd_chk("R8 alarm set two edges after tick", 3'd7, 16'h3);
        check("R9 alarm irq asserted", DATA_W'(irq_alm), 16'h1);
        check("R9 update irq stays masked", DATA_W'(irq_upd), '0);
        pulse_tick();
        @(negedge clk);
        rd_chk("R8 alarm flag sticky", 3'd7, 16'h3);
        wr_reg(3'd7, 16'h2);
        rd_chk("R8 alarm W1C", 3'd7, 16'h1);
        check("R9 alarm irq low after clear", DATA_W'(irq_alm), '0);
        pulse_tick();
        @(negedge clk);
        rd_chk("R8 no match, no alarm", 3'd7, 16'h1);
    endtask

    task automatic t_alarm_commit();
        wr_reg(3'd7, 16'h3);
        wr_reg(3'd5, 16'd3);
        wr_reg(3'd0, 16'h11);
        @(negedge clk);
        rd_chk("R8 day mismatch, no alarm", 3'd7, 16'h0);
        wr_reg(3'd5, 16'd2);
        wr_reg(3'd0, 16'h11);
        rd_chk("R8 alarm not yet set after commit edge", 3'd7, 16'h0);
        @(negedge clk);
        rd_chk("R8 alarm set by commit", 3'd7, 16'h2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_staged_commit();
        t_tick_and_carry();
        t_day_wrap();
        t_commit_tick();
        t_update_irq();
        t_alarm_tick();
        t_alarm_commit();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule